// File: doc/BRIEF.md
# March-Test Defect Map Generator

This block is a self-test engine that sweeps a memory array with a march pattern and records the result as one pass/fail bit per fetch group. A fetch group is a run of consecutive array words that are read together. The resulting bitmap lets the surrounding cache send accesses aimed at bad fetch groups to spare storage instead. The engine drives the array's single read/write port. It holds the defect map itself and exposes the whole map and a dirty flag per map row.

Three kinds of event start a run. A whole-array request tests every fetch group, for example at start-up or on demand. A thermal event carries an inclusive fetch-group range, and only that range is retested. A programmable idle period can also launch whole-array runs on its own. Map bits only accumulate, so a retest can add defects but never clear one.

Each map row groups a fixed number of bits, and a row is flagged dirty whenever one of its bits changes. The flag stays set until write-back is acknowledged, so that the rows can be saved before the operating point changes. Each run ends with a one-cycle done pulse and the number of fetch groups newly found bad during that run.

Top module: `defmap_march_bist`

## Requirements
- R1: For each array word the engine issues, on consecutive cycles, write all-ones, write all-zeros, read, write all-ones, read, followed by one cycle with no array access. Each word therefore takes 6 cycles. The first read is expected to return all-zeros and the second all-ones. Read data arrives on `arr_rdata` one cycle after the read is issued.
- R2: A run visits words in ascending address order, from `lo*FGW` to `hi*FGW+FGW-1`, where the array address is `{fetch_group, word}`. A run over N fetch groups keeps `busy` high for exactly N*FGW*6 cycles.
- R3: A fetch group is marked defective when any read of any of its words returns data different from the expected pattern. Bit f of `defect_map` belongs to fetch group f.
- R4: A set map bit is never cleared by any later run, even when the location later reads back correctly.
- R5: Bit r of `row_dirty` belongs to map row r, which holds the fetch groups f with f / ROW_BITS = r. The bit is set when a map bit in that row goes from 0 to 1. A `wb_ack` pulse clears all dirty bits, and a set in the same cycle takes precedence over the clear.
- R6: `done` is high for exactly one cycle, in the cycle after the last check, with `busy` low. `new_cnt` then holds the number of map bits that changed from 0 to 1 during the run, and keeps that value until the next run starts.
- R7: `start_full` tests fetch groups 0 to NFG-1. `heat_evt` tests `heat_lo` to `heat_hi` inclusive. When both are asserted together, the whole-array test is the one performed. A range with `heat_lo` > `heat_hi` makes no array access, and `done` pulses in the next cycle with `new_cnt` = 0.
- R8: `start_full` and `heat_evt` are ignored while `busy` is high.
- R9: When `period_cfg` is P > 0, a whole-array run begins after exactly P consecutive idle cycles. When P = 0, no run starts on its own.
- R10: After reset, `busy`, `done`, `arr_en`, `new_cnt`, `defect_map` and `row_dirty` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_full | input | 1 | Pulse: test the whole array |
| heat_evt | input | 1 | Pulse: retest the heated range |
| heat_lo | input | NFG_LG2 | First fetch group of the heated range |
| heat_hi | input | NFG_LG2 | Last fetch group of the heated range |
| period_cfg | input | PERW | Idle cycles between automatic runs; 0 disables them |
| wb_ack | input | 1 | Dirty rows have been written back; clear the dirty flags |
| arr_en | output | 1 | Array access enable |
| arr_we | output | 1 | Array write (1) or read (0) |
| arr_addr | output | NFG_LG2+FGW_LG2 | Array word address {fetch group, word} |
| arr_wdata | output | DW | Array write data |
| arr_rdata | input | DW | Array read data, valid one cycle after a read |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| new_cnt | output | NFG_LG2+1 | Fetch groups newly marked bad in the last run |
| defect_map | output | 2**NFG_LG2 | One bit per fetch group, 1 = defective |
| row_dirty | output | 2**(NFG_LG2-ROW_LG2) | One dirty flag per map row |

## Verification
The bench builds the engine with its default values: 32 fetch groups of 2 words of 8 bits, and 4 map rows of 8 bits. A whole-array run then takes 384 cycles, which keeps dozens of runs well inside the time limit. At this size a single-group retest can be swept over every fetch group, alternating stuck-at-one and stuck-at-zero faults on both words and on every bit lane. This drives each map bit, each dirty row and the per-run count through their transitions. The small array also allows whole-array runs with every group faulty, repeated runs after faults are removed, empty and overlapping ranges, and exact timing of the idle-period trigger.

// File: rtl/dmb_pkg.sv
package dmb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR1A,
        ST_WR0,
        ST_RD0,
        ST_WR1B,
        ST_RD1,
        ST_CHK
    } mstep_e;

    localparam int unsigned STEPS_PER_WORD = 6;

endpackage

// File: rtl/dmb_seq.sv
module dmb_seq
    import dmb_pkg::*;
#(
    parameter int unsigned FGA = 5,
    parameter int unsigned WLG = 1,
    parameter int unsigned DW  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_full,
    input  logic                 trig_heat,
    input  logic [FGA-1:0]       heat_lo,
    input  logic [FGA-1:0]       heat_hi,
    output logic                 arr_en,
    output logic                 arr_we,
    output logic [FGA+WLG-1:0]   arr_addr,
    output logic [DW-1:0]        arr_wdata,
    input  logic [DW-1:0]        arr_rdata,
    output logic                 busy,
    output logic                 done,
    output logic                 run_start,
    output logic                 commit,
    output logic [FGA-1:0]       commit_fg,
    output logic                 commit_fail
);

    localparam logic [FGA-1:0] FG_LAST   = '1;
    localparam logic [WLG-1:0] WORD_LAST = '1;
    localparam logic [DW-1:0]  ONES      = '1;
    localparam logic [DW-1:0]  ZEROS     = '0;

    typedef struct packed {
        mstep_e         st;
        logic [FGA-1:0] fg;
        logic [WLG-1:0] word;
        logic [FGA-1:0] hi;
        logic           fail;
        logic           done;
    } seq_t;

    seq_t s_q, s_d;
    logic [FGA-1:0] lo_v, hi_v;
    logic           mism;

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        run_start   = 1'b0;
        commit      = 1'b0;
        commit_fail = 1'b0;
        arr_en      = 1'b0;
        arr_we      = 1'b0;
        arr_wdata   = ZEROS;
        mism        = 1'b0;
        lo_v        = trig_full ? '0 : heat_lo;
        hi_v        = trig_full ? FG_LAST : heat_hi;

        case (s_q.st)
            ST_IDLE: begin
                if (trig_full || trig_heat) begin
                    run_start = 1'b1;
                    if (lo_v > hi_v) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st   = ST_WR1A;
                        s_d.fg   = lo_v;
                        s_d.word = '0;
                        s_d.hi   = hi_v;
                        s_d.fail = 1'b0;
                    end
                end
            end
            ST_WR1A: begin
                arr_en    = 1'b1;
                arr_we    = 1'b1;
                arr_wdata = ONES;
                s_d.st    = ST_WR0;
            end
            ST_WR0: begin
                arr_en    = 1'b1;
                arr_we    = 1'b1;
                arr_wdata = ZEROS;
                s_d.st    = ST_RD0;
            end
            ST_RD0: begin
                arr_en = 1'b1;
                s_d.st = ST_WR1B;
            end
            ST_WR1B: begin
                arr_en    = 1'b1;
                arr_we    = 1'b1;
                arr_wdata = ONES;
                mism      = (arr_rdata != ZEROS);
                s_d.fail  = s_q.fail | mism;
                s_d.st    = ST_RD1;
            end
            ST_RD1: begin
                arr_en = 1'b1;
                s_d.st = ST_CHK;
            end
            ST_CHK: begin
                mism = (arr_rdata != ONES);
                if (s_q.word == WORD_LAST) begin
                    commit      = 1'b1;
                    commit_fail = s_q.fail | mism;
                    s_d.fail    = 1'b0;
                    s_d.word    = '0;
                    if (s_q.fg == s_q.hi) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.fg = s_q.fg + 1'b1;
                        s_d.st = ST_WR1A;
                    end
                end else begin
                    s_d.fail = s_q.fail | mism;
                    s_d.word = s_q.word + 1'b1;
                    s_d.st   = ST_WR1A;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, fg: '0, word: '0, hi: '0, fail: 1'b0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign done      = s_q.done;
    assign arr_addr  = {s_q.fg, s_q.word};
    assign commit_fg = s_q.fg;

    // R6: the end-of-run pulse lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: every run that drops busy raises done at the same time
    a_r6_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R2: addresses never go down inside a run
    a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_en && $past(arr_en)) |-> (arr_addr >= $past(arr_addr)));

    // R1: only solid patterns are ever written
    a_r1_solid_write: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_en && arr_we) |-> (arr_wdata == ONES || arr_wdata == ZEROS));

    // R8: the range end captured at start is held for the whole run
    a_r8_range_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(s_q.hi));

endmodule

// File: rtl/dmb_map.sv
module dmb_map #(
    parameter int unsigned FGA    = 5,
    parameter int unsigned ROWLG  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run_start,
    input  logic                        commit,
    input  logic [FGA-1:0]              commit_fg,
    input  logic                        commit_fail,
    input  logic                        wb_ack,
    output logic [(1<<FGA)-1:0]         defect_map,
    output logic [(1<<(FGA-ROWLG))-1:0] row_dirty,
    output logic [FGA:0]                new_cnt
);

    localparam int unsigned NFG   = 1 << FGA;
    localparam int unsigned NROW  = 1 << (FGA - ROWLG);
    localparam int unsigned CNT_W = FGA + 1;

    typedef struct packed {
        logic [NFG-1:0]   map;
        logic [NROW-1:0]  dirty;
        logic [CNT_W-1:0] cnt;
    } map_t;

    map_t m_q, m_d;
    logic set_en;
    logic [FGA-ROWLG-1:0] row_v;

    always_comb begin
        m_d    = m_q;
        row_v  = commit_fg[FGA-1:ROWLG];
        set_en = commit && commit_fail && !m_q.map[commit_fg];
        if (run_start) begin
            m_d.cnt = '0;
        end
        if (wb_ack) begin
            m_d.dirty = '0;
        end
        if (set_en) begin
            m_d.map[commit_fg] = 1'b1;
            m_d.dirty[row_v]   = 1'b1;
            m_d.cnt            = m_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign defect_map = m_q.map;
    assign row_dirty  = m_q.dirty;
    assign new_cnt    = m_q.cnt;

    // R4: no map bit ever returns to zero
    a_r4_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_q.map & $past(m_q.map)) == $past(m_q.map)));

    // R5: a newly set bit leaves its row flagged
    a_r5_row_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> row_dirty[$past(row_v)]);

    // R6: the run count cannot exceed the number of fetch groups
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        new_cnt <= CNT_W'(NFG));

endmodule

// File: rtl/dmb_timer.sv
module dmb_timer #(
    parameter int unsigned PERW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PERW-1:0] period_cfg,
    input  logic            busy,
    output logic            tick
);

    logic [PERW-1:0] cnt_q, cnt_d;

    always_comb begin
        tick  = 1'b0;
        cnt_d = cnt_q;
        if (busy || period_cfg == '0) begin
            cnt_d = '0;
        end else if (cnt_q >= period_cfg - 1'b1) begin
            tick  = 1'b1;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R9: the idle count is reset while a run is in progress
    a_r9_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cnt_q == '0));

endmodule

// File: rtl/defmap_march_bist.sv
module defmap_march_bist #(
    parameter int unsigned NFG_LG2 = 5,
    parameter int unsigned FGW_LG2 = 1,
    parameter int unsigned ROW_LG2 = 3,
    parameter int unsigned DW      = 8,
    parameter int unsigned PERW    = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_full,
    input  logic                              heat_evt,
    input  logic [NFG_LG2-1:0]                heat_lo,
    input  logic [NFG_LG2-1:0]                heat_hi,
    input  logic [PERW-1:0]                   period_cfg,
    input  logic                              wb_ack,
    output logic                              arr_en,
    output logic                              arr_we,
    output logic [NFG_LG2+FGW_LG2-1:0]        arr_addr,
    output logic [DW-1:0]                     arr_wdata,
    input  logic [DW-1:0]                     arr_rdata,
    output logic                              busy,
    output logic                              done,
    output logic [NFG_LG2:0]                  new_cnt,
    output logic [(1<<NFG_LG2)-1:0]           defect_map,
    output logic [(1<<(NFG_LG2-ROW_LG2))-1:0] row_dirty
);

    logic                tick;
    logic                trig_full;
    logic                run_start;
    logic                commit;
    logic [NFG_LG2-1:0]  commit_fg;
    logic                commit_fail;

    assign trig_full = start_full | tick;

    dmb_timer #(.PERW(PERW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_cfg (period_cfg),
        .busy       (busy),
        .tick       (tick)
    );

    dmb_seq #(.FGA(NFG_LG2), .WLG(FGW_LG2), .DW(DW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_full   (trig_full),
        .trig_heat   (heat_evt),
        .heat_lo     (heat_lo),
        .heat_hi     (heat_hi),
        .arr_en      (arr_en),
        .arr_we      (arr_we),
        .arr_addr    (arr_addr),
        .arr_wdata   (arr_wdata),
        .arr_rdata   (arr_rdata),
        .busy        (busy),
        .done        (done),
        .run_start   (run_start),
        .commit      (commit),
        .commit_fg   (commit_fg),
        .commit_fail (commit_fail)
    );

    dmb_map #(.FGA(NFG_LG2), .ROWLG(ROW_LG2)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_start   (run_start),
        .commit      (commit),
        .commit_fg   (commit_fg),
        .commit_fail (commit_fail),
        .wb_ack      (wb_ack),
        .defect_map  (defect_map),
        .row_dirty   (row_dirty),
        .new_cnt     (new_cnt)
    );

    // R9: an idle-period expiry always launches a run
    a_r9_tick_starts_run: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> busy);

endmodule

// File: tb/tb_defmap_march_bist.sv
module tb_defmap_march_bist;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NFG = 32;
    localparam int FGW = 2;
    localparam int DEP = NFG * FGW;
    localparam int RB  = 8;
    localparam int NR  = NFG / RB;
    localparam int DW  = 8;
    localparam int CPW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_full = 1'b0, heat_evt = 1'b0, wb_ack = 1'b0;
    logic [4:0] heat_lo = '0, heat_hi = '0;
    logic [15:0] period_cfg = '0;
    logic arr_en, arr_we, busy, done;
    logic [5:0] arr_addr;
    logic [DW-1:0] arr_wdata, arr_rdata;
    logic [5:0] new_cnt;
    logic [NFG-1:0] defect_map;
    logic [NR-1:0] row_dirty;

    always #2.5 clk = ~clk;

    defmap_march_bist dut (
        .clk(clk), .rst_n(rst_n), .start_full(start_full), .heat_evt(heat_evt),
        .heat_lo(heat_lo), .heat_hi(heat_hi), .period_cfg(period_cfg), .wb_ack(wb_ack),
        .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_rdata(arr_rdata), .busy(busy), .done(done), .new_cnt(new_cnt),
        .defect_map(defect_map), .row_dirty(row_dirty)
    );

    // array model: reads return stored data with stuck bits applied, one cycle later
    logic [DW-1:0] mem [DEP];
    logic [DW-1:0] s1 [DEP];
    logic [DW-1:0] s0 [DEP];
    logic [DW-1:0] rdq = '0;
    assign arr_rdata = rdq;

    always @(posedge clk) begin
        if (arr_en && arr_we) mem[arr_addr] <= arr_wdata;
        if (arr_en && !arr_we) rdq <= (mem[arr_addr] | s1[arr_addr]) & ~s0[arr_addr];
    end

    // access monitor
    int nwr, nrd, order_bad, pat_bad, amin, amax, last_a, pos, waddr;
    bit have_last;
    always @(negedge clk) begin
        if (rst_n && arr_en) begin
            if (arr_we) nwr++; else nrd++;
            if (have_last && int'(arr_addr) < last_a) order_bad++;
            if (int'(arr_addr) < amin) amin = int'(arr_addr);
            if (int'(arr_addr) > amax) amax = int'(arr_addr);
            last_a = int'(arr_addr);
            have_last = 1'b1;
            if (pos == 0) waddr = int'(arr_addr);
            else if (int'(arr_addr) != waddr) pat_bad++;
            case (pos)
                0, 3: if (!(arr_we && arr_wdata == 8'hFF)) pat_bad++;
                1:    if (!(arr_we && arr_wdata == 8'h00)) pat_bad++;
                default: if (arr_we) pat_bad++;
            endcase
            pos = (pos + 1) % 5;
        end
    end

    int n_chk = 0, n_fail = 0;
    logic [NFG-1:0] exp_map = '0;
    logic [NR-1:0]  exp_dirty = '0;

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic mon_clear();
        nwr = 0; nrd = 0; order_bad = 0; pat_bad = 0;
        amin = 1 << 30; amax = -1; last_a = 0; pos = 0; waddr = 0; have_last = 1'b0;
    endtask

    function automatic bit fg_bad(input int f);
        bit b = 1'b0;
        for (int w = 0; w < FGW; w++)
            if (s1[f*FGW+w] != '0 || s0[f*FGW+w] != '0) b = 1'b1;
        return b;
    endfunction

    task automatic clear_faults();
        for (int a = 0; a < DEP; a++) begin s1[a] = '0; s0[a] = '0; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_map = '0;
        exp_dirty = '0;
        @(negedge clk);
    endtask

    task automatic do_wb();
        @(negedge clk); wb_ack = 1'b1;
        @(negedge clk); wb_ack = 1'b0;
        exp_dirty = '0;
        chk("R5", "dirty after write-back", 64'(row_dirty), 64'(exp_dirty));
    endtask

    // trigger a run, measure it, then check all visible results
    task automatic run_chk(input bit full, input bit heat, input int lo, input int hi, input bit poke);
        int bcyc = 0;
        int elo, ehi, nw;
        logic [NFG-1:0] newly = '0;
        mon_clear();
        @(negedge clk);
        start_full = full; heat_evt = heat;
        heat_lo = 5'(lo); heat_hi = 5'(hi);
        @(negedge clk);
        start_full = 1'b0; heat_evt = 1'b0;
        while (busy) begin
            bcyc++;
            if (poke && bcyc == 100) begin start_full = 1'b1; heat_evt = 1'b1; heat_lo = 0; heat_hi = 0; end
            else begin start_full = 1'b0; heat_evt = 1'b0; end
            @(negedge clk);
        end
        start_full = 1'b0; heat_evt = 1'b0;
        elo = full ? 0 : lo;
        ehi = full ? NFG - 1 : hi;
        nw = (ehi >= elo) ? (ehi - elo + 1) * FGW : 0;
        chk("R6", "done at end", 64'(done), 64'd1);
        chk("R2", "busy cycles", 64'(bcyc), 64'(nw * CPW));
        chk("R1", "writes", 64'(nwr), 64'(nw * 3));
        chk("R1", "reads", 64'(nrd), 64'(nw * 2));
        chk("R1", "step pattern", 64'(pat_bad), 64'd0);
        chk("R2", "order", 64'(order_bad), 64'd0);
        if (nw > 0) begin
            chk("R2", "lowest addr", 64'(amin), 64'(elo * FGW));
            chk("R2", "highest addr", 64'(amax), 64'(ehi * FGW + FGW - 1));
        end
        @(negedge clk);
        chk("R6", "done width", 64'(done), 64'd0);
        for (int f = elo; f <= ehi; f++)
            if (fg_bad(f) && !exp_map[f]) newly[f] = 1'b1;
        exp_map = exp_map | newly;
        for (int f = 0; f < NFG; f++)
            if (newly[f]) exp_dirty[f / RB] = 1'b1;
        chk("R6", "new count", 64'(new_cnt), 64'($countones(newly)));
        chk("R3", "map", 64'(defect_map), 64'(exp_map));
        chk("R5", "dirty", 64'(row_dirty), 64'(exp_dirty));
    endtask

    initial begin
        clear_faults();
        for (int a = 0; a < DEP; a++) mem[a] = '0;
        mon_clear();
        repeat (3) @(negedge clk);
        chk("R10", "busy in reset", 64'(busy), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "busy", 64'(busy), 64'd0);
        chk("R10", "done", 64'(done), 64'd0);
        chk("R10", "arr_en", 64'(arr_en), 64'd0);
        chk("R10", "count", 64'(new_cnt), 64'd0);
        chk("R10", "map", 64'(defect_map), 64'd0);
        chk("R10", "dirty", 64'(row_dirty), 64'd0);

        // clean array, whole run
        run_chk(1'b1, 1'b0, 0, 0, 1'b0);

        // single-group retest swept over every fetch group
        for (int i = 0; i < NFG; i++) begin
            if (i % 2 == 0) s1[i*FGW + (i/2) % FGW][i % DW] = 1'b1;
            else            s0[i*FGW + (i/2) % FGW][i % DW] = 1'b1;
            run_chk(1'b0, 1'b1, i, i, 1'b0);
            if (i % RB == RB - 1) do_wb();
        end

        // everything bad already: nothing new, dirty stays clear (R4, R5)
        run_chk(1'b1, 1'b0, 0, 0, 1'b0);
        chk("R4", "all bits set", 64'(defect_map), 64'(32'hFFFF_FFFF));

        // fresh map with a few faults
        do_reset();
        clear_faults();
        s1[3*FGW][0] = 1'b1;
        s0[9*FGW+1][7] = 1'b1;
        s1[10*FGW+1][4] = 1'b1;
        s0[20*FGW][2] = 1'b1;
        s1[31*FGW+1][5] = 1'b1;
        run_chk(1'b0, 1'b1, 8, 15, 1'b0);          // R7 heated range only
        run_chk(1'b1, 1'b1, 8, 15, 1'b0);          // R7 whole wins
        clear_faults();
        run_chk(1'b1, 1'b0, 0, 0, 1'b0);           // R4 repaired cells keep bits
        chk("R4", "map kept", 64'(defect_map), 64'(32'h8010_0608));
        run_chk(1'b0, 1'b1, 5, 4, 1'b0);           // R7 empty range
        s0[17*FGW][1] = 1'b1;
        run_chk(1'b1, 1'b0, 0, 0, 1'b1);           // R8 retrigger ignored
        clear_faults();

        // idle-period trigger
        begin
            int w = 0, idle = 0, bc = 0;
            @(negedge clk); period_cfg = 16'd20;
            while (!busy && w < 1000) begin w++; @(negedge clk); end
            chk("R9", "auto run started", 64'(busy), 64'd1);
            while (busy) @(negedge clk);
            while (!busy && idle < 1000) begin idle++; @(negedge clk); end
            chk("R9", "idle gap", 64'(idle), 64'd20);
            @(negedge clk); period_cfg = 16'd0;
            while (busy) begin bc++; @(negedge clk); end
            chk("R9", "auto run length", 64'(bc + 1), 64'(NFG * FGW * CPW));
            w = 0;
            repeat (600) begin @(negedge clk); if (busy) w++; end
            chk("R9", "disabled stays idle", 64'(w), 64'd0);
            chk("R4", "map after auto runs", 64'(defect_map), 64'(exp_map));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule